// File: doc/BRIEF.md
# Source-Addressed Spike Output Port

This block sits at the edge of a time-multiplexed spiking network engine. It presents a chosen subset of the network's spike activity to an outside consumer. It keeps its own full copy of the network activity, one bit per node, where a node is any input or neuron. That copy is filled from a broadcast bus while the engine is in its communication phase.

A separately loaded table names, for each of 384 output slots, the node whose activity that slot reports. When the engine leaves the communication phase and enters the update phase, the block builds six 64-bit frames. In each frame, every channel bit is taken from the activity copy at the node named for that slot. The frames are sent one by one over a four-phase request/acknowledge handshake. The consumer may run from an unrelated clock, so its acknowledge line is synchronised before use. A sideband line marks the first frame of each set.

Top module: `spike_out_port`

## Requirements
- R1: While reset is asserted, out_req and out_first are low and out_data is all zeros.
- R2: A set of frames starts only when comm_phase goes from high to low. Holding comm_phase at either level, or raising it, starts nothing.
- R3: Slot number s = f*64 + c is loaded with a node number through cfg_we/cfg_slot/cfg_node. In frame f, out_data[c] equals the stored activity bit of the node that slot s names.
- R4: A cycle with bcast_valid high sets the activity bit of node bcast_node to bcast_spike only while comm_phase is high. At all other times the write is ignored.
- R5: Each frame uses four phases. out_req rises with the frame, falls only after out_ack has been seen high, and the next frame's out_req rises only after out_ack has been seen low again.
- R6: While out_req is high, out_data and out_first do not change.
- R7: Frames go out in order 0 to 5. out_first is high with frame 0 only. After frame 5 no further request is made until the next start.
- R8: out_ack passes through a two-stage synchroniser. out_req falls no earlier than the third rising clock edge after out_ack rises.
- R9: A high-to-low change of comm_phase during a frame set neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comm_phase | input | 1 | High during the communication phase, low during the update phase |
| cfg_we | input | 1 | Write strobe for the slot address table |
| cfg_slot | input | 9 | Output slot to load (frame*64 + channel) |
| cfg_node | input | 9 | Node number stored for that slot |
| bcast_valid | input | 1 | Broadcast activity write strobe |
| bcast_node | input | 9 | Node whose activity is broadcast |
| bcast_spike | input | 1 | Activity value broadcast |
| out_data | output | 64 | Current frame, one bit per channel |
| out_first | output | 1 | Marks frame 0 of a set |
| out_req | output | 1 | Frame request toward the consumer |
| out_ack | input | 1 | Consumer acknowledge, asynchronous |

## Verification
A wrong slot-table entry or a corrupted activity bit shows up as a single wrong channel bit in the frame that slot belongs to. It is visible as soon as that frame's request rises. A handshake state or frame counter stuck or skipped shows up within one frame, as a missing, repeated or early request, or as out_first in the wrong place. A synchroniser that is too short makes out_req fall one edge early after out_ack rises. The bench measures that latency on every frame.

// File: rtl/spo_pkg.sv
package spo_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_SEND = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;
endpackage

// File: rtl/spo_sync2.sv
module spo_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/spo_addr_mem.sv
module spo_addr_mem #(
  parameter int CHANNELS = 64,
  parameter int FRAMES   = 6,
  parameter int NODE_W   = 9,
  parameter int SLOT_W   = 9,
  parameter int FRAME_W  = 3
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [SLOT_W-1:0]          wr_slot,
  input  logic [NODE_W-1:0]          wr_node,
  input  logic [FRAME_W-1:0]         rd_frame,
  output logic [CHANNELS*NODE_W-1:0] rd_nodes
);
  localparam int SLOTS = CHANNELS * FRAMES;

  logic [NODE_W-1:0] table_q [SLOTS];
  logic              wr_ok;

  assign wr_ok = wr_en && (wr_slot < SLOT_W'(SLOTS));

  // memory-style storage: loaded before use, no reset
  always_ff @(posedge clk) begin
    if (wr_ok) table_q[wr_slot] <= wr_node;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_rd
    logic [SLOT_W-1:0] rd_idx;
    assign rd_idx = SLOT_W'(rd_frame) * SLOT_W'(CHANNELS) + SLOT_W'(c);
    assign rd_nodes[c*NODE_W +: NODE_W] = table_q[rd_idx];
  end
endmodule

// File: rtl/spo_state_mem.sv
module spo_state_mem #(
  parameter int NODES    = 512,
  parameter int CHANNELS = 64,
  parameter int NODE_W   = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [NODE_W-1:0]          wr_node,
  input  logic                       wr_spike,
  input  logic [CHANNELS*NODE_W-1:0] rd_nodes,
  output logic [CHANNELS-1:0]        rd_bits
);
  logic [NODES-1:0] act_q;
  logic [NODES-1:0] act_n;
  logic             wr_ok;

  assign wr_ok = wr_en && (32'(wr_node) < NODES);

  always_comb begin
    act_n = act_q;
    if (wr_ok) act_n[wr_node] = wr_spike;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else if (wr_ok) act_q <= act_n;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_pick
    assign rd_bits[c] = act_q[rd_nodes[c*NODE_W +: NODE_W]];
  end
endmodule

// File: rtl/spo_hs.sv
module spo_hs
  import spo_pkg::*;
#(
  parameter int CHANNELS = 64,
  parameter int FRAMES   = 6,
  parameter int FRAME_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ack_s,
  input  logic [CHANNELS-1:0] gather_bits,
  output logic [FRAME_W-1:0]  gather_frame,
  output logic [CHANNELS-1:0] data,
  output logic                first,
  output logic                req
);
  localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAMES - 1);

  hs_state_e          st_q, st_n;
  logic [FRAME_W-1:0] idx_q, idx_n;
  logic               req_q, req_n;
  logic               first_q, first_n;
  logic [CHANNELS-1:0] data_q;
  logic               load;

  assign gather_frame = (st_q == HS_HOLD) ? idx_q + FRAME_W'(1) : '0;

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    req_n   = req_q;
    first_n = first_q;
    load    = 1'b0;
    case (st_q)
      HS_IDLE: begin
        if (start) begin
          load    = 1'b1;
          idx_n   = '0;
          first_n = 1'b1;
          req_n   = 1'b1;
          st_n    = HS_SEND;
        end
      end
      HS_SEND: begin
        if (ack_s) begin
          req_n = 1'b0;
          st_n  = HS_HOLD;
        end
      end
      HS_HOLD: begin
        if (!ack_s) begin
          first_n = 1'b0;
          if (idx_q == LAST) begin
            idx_n = '0;
            st_n  = HS_IDLE;
          end else begin
            load  = 1'b1;
            idx_n = idx_q + FRAME_W'(1);
            req_n = 1'b1;
            st_n  = HS_SEND;
          end
        end
      end
      default: st_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_IDLE;
      idx_q   <= '0;
      req_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      req_q   <= req_n;
      first_q <= first_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (load) data_q <= gather_bits;
  end

  assign data  = data_q;
  assign first = first_q;
  assign req   = req_q;
endmodule

// File: rtl/spike_out_port.sv
module spike_out_port #(
  parameter int CHANNELS = 64,
  parameter int FRAMES   = 6,
  parameter int NODES    = 512,
  parameter int NODE_W   = $clog2(NODES),
  parameter int SLOT_W   = $clog2(CHANNELS * FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                comm_phase,
  input  logic                cfg_we,
  input  logic [SLOT_W-1:0]   cfg_slot,
  input  logic [NODE_W-1:0]   cfg_node,
  input  logic                bcast_valid,
  input  logic [NODE_W-1:0]   bcast_node,
  input  logic                bcast_spike,
  output logic [CHANNELS-1:0] out_data,
  output logic                out_first,
  output logic                out_req,
  input  logic                out_ack
);
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;

  logic                       comm_d_q;
  logic                       start;
  logic                       ack_s;
  logic [FRAME_W-1:0]         gather_frame;
  logic [CHANNELS*NODE_W-1:0] slot_nodes;
  logic [CHANNELS-1:0]        gather_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comm_d_q <= 1'b0;
    else        comm_d_q <= comm_phase;
  end

  assign start = comm_d_q && !comm_phase;

  spo_sync2 u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (out_ack),
    .q     (ack_s)
  );

  spo_addr_mem #(
    .CHANNELS (CHANNELS),
    .FRAMES   (FRAMES),
    .NODE_W   (NODE_W),
    .SLOT_W   (SLOT_W),
    .FRAME_W  (FRAME_W)
  ) u_addr (
    .clk      (clk),
    .wr_en    (cfg_we),
    .wr_slot  (cfg_slot),
    .wr_node  (cfg_node),
    .rd_frame (gather_frame),
    .rd_nodes (slot_nodes)
  );

  spo_state_mem #(
    .NODES    (NODES),
    .CHANNELS (CHANNELS),
    .NODE_W   (NODE_W)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bcast_valid && comm_phase),
    .wr_node  (bcast_node),
    .wr_spike (bcast_spike),
    .rd_nodes (slot_nodes),
    .rd_bits  (gather_bits)
  );

  spo_hs #(
    .CHANNELS (CHANNELS),
    .FRAMES   (FRAMES),
    .FRAME_W  (FRAME_W)
  ) u_hs (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ack_s        (ack_s),
    .gather_bits  (gather_bits),
    .gather_frame (gather_frame),
    .data         (out_data),
    .first        (out_first),
    .req          (out_req)
  );
endmodule

// File: rtl/spike_out_port_chk.sv
module spike_out_port_chk #(
  parameter int CHANNELS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                comm_phase,
  input logic [CHANNELS-1:0] out_data,
  input logic                out_first,
  input logic                out_req,
  input logic                out_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!out_req && !out_first && out_data == '0)
        else $error("R1 outputs active in reset");
    end
  end

  assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_req) && out_first) |-> (!$past(comm_phase, 1) && $past(comm_phase, 2)))
    else $error("R2 set started without comm_phase fall");

  assert_req_rise_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack, 2))
    else $error("R5 request raised while ack high");

  assert_req_fall_ack_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> ($past(out_ack, 2) && $past(out_ack, 3)))
    else $error("R8 request dropped before ack synchronised");

  assert_frame_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> ($stable(out_data) && $stable(out_first)))
    else $error("R6 frame changed under request");
endmodule

bind spike_out_port spike_out_port_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .comm_phase (comm_phase),
  .out_data   (out_data),
  .out_first  (out_first),
  .out_req    (out_req),
  .out_ack    (out_ack)
);

// File: tb/spike_out_port_test.sv
module spike_out_port_test;
  localparam int CH = 64;
  localparam int FR = 6;
  localparam int NN = 512;

  logic          clk;
  logic          rst_n;
  logic          comm_phase;
  logic          cfg_we;
  logic [8:0]    cfg_slot;
  logic [8:0]    cfg_node;
  logic          bcast_valid;
  logic [8:0]    bcast_node;
  logic          bcast_spike;
  logic [CH-1:0] out_data;
  logic          out_first;
  logic          out_req;
  logic          out_ack;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  bit ref_state [NN];
  int ref_addr [CH*FR];

  spike_out_port uut (
    .clk(clk), .rst_n(rst_n), .comm_phase(comm_phase),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_node(cfg_node),
    .bcast_valid(bcast_valid), .bcast_node(bcast_node), .bcast_spike(bcast_spike),
    .out_data(out_data), .out_first(out_first), .out_req(out_req), .out_ack(out_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog(all): actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_slot(input int s, input int node);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 9'(s); cfg_node = 9'(node);
    @(negedge clk);
    cfg_we = 1'b0;
    ref_addr[s] = node;
  endtask

  // broadcast write; the reference follows only if comm_phase is high (R4)
  task automatic bcast(input int node, input bit v);
    @(negedge clk);
    bcast_valid = 1'b1; bcast_node = 9'(node); bcast_spike = v;
    @(negedge clk);
    bcast_valid = 1'b0;
    if (comm_phase) ref_state[node] = v;
  endtask

  task automatic no_req_for(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_req) seen = 1;
    end
    check(!seen, req, 64'(seen), 64'd0);
  endtask

  task automatic take_frame(input int f, input string dtag, input bit poke);
    logic [63:0] d0;
    logic [63:0] exp;
    logic f0;
    int n;
    int lat;
    n = 0;
    while (!out_req && n < 300) begin @(negedge clk); n++; end
    check(out_req, "R5 request for frame", 64'(out_req), 64'd1);
    d0 = out_data; f0 = out_first;
    for (int c = 0; c < CH; c++) exp[c] = ref_state[ref_addr[f*CH + c]];
    check(d0 == exp, dtag, d0, exp);
    check(f0 == (f == 0), "R7 first marker", 64'(f0), 64'(f == 0));
    if (poke) begin
      // R9: a fresh comm_phase fall mid-set must not restart it
      comm_phase = 1'b1; @(negedge clk); @(negedge clk); comm_phase = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(out_data == d0 && out_first == f0, "R6 stable while requested", out_data, d0);
    out_ack = 1'b1;
    lat = 0;
    while (out_req && lat < 300) begin @(negedge clk); lat++; end
    check(!out_req, "R5 request drops after ack", 64'(out_req), 64'd0);
    check(lat >= 3, "R8 synchroniser latency", 64'(lat), 64'd3);
    repeat (2) @(negedge clk);
    check(!out_req, "R5 no new request while ack high", 64'(out_req), 64'd0);
    out_ack = 1'b0;
  endtask

  task automatic run_set(input string dtag, input bit poke);
    for (int f = 0; f < FR; f++) take_frame(f, dtag, poke && f == 1);
    no_req_for(80, "R7 no seventh frame");
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!out_req && !out_first, "R1 handshake idle in reset", {62'd0, out_req, out_first}, 64'd0);
    check(out_data == '0, "R1 data cleared in reset", out_data, 64'd0);
  endtask

  task automatic t_no_spurious_start;
    no_req_for(40, "R2 steady low level");
    comm_phase = 1'b1;
    no_req_for(40, "R2 rising comm_phase");
  endtask

  task automatic t_pattern_a;
    for (int s = 0; s < CH*FR; s++) load_slot(s, (s*37 + 5) % NN);
    for (int a = 0; a < NN; a++) bcast(a, ((a*a + a) % 5) < 2);
    @(negedge clk); comm_phase = 1'b0;
    run_set("R3 frame contents A", 1'b0);
  endtask

  task automatic t_ignored_writes;
    for (int a = 0; a < NN; a += 3) bcast(a, !ref_state[a]);
    comm_phase = 1'b1; @(negedge clk); comm_phase = 1'b0;
    run_set("R4 update-phase writes ignored", 1'b0);
  endtask

  task automatic t_pattern_b;
    for (int s = 0; s < CH*FR; s++) load_slot(s, (s % 2 == 0) ? (NN - 1 - s) : 7);
    @(negedge clk); comm_phase = 1'b1;
    for (int a = 0; a < NN; a++) bcast(a, ((a >> 2) % 2) == 1);
    bcast(7, 1'b1);
    @(negedge clk); comm_phase = 1'b0;
    run_set("R3 frame contents B", 1'b0);
  endtask

  task automatic t_fall_mid_set;
    @(negedge clk); comm_phase = 1'b1;
    @(negedge clk); comm_phase = 1'b0;
    run_set("R9 contents with mid-set fall", 1'b1);
  endtask

  initial begin
    rst_n = 1'b1; comm_phase = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_node = '0;
    bcast_valid = 1'b0; bcast_node = '0; bcast_spike = 1'b0; out_ack = 1'b0;
    for (int a = 0; a < NN; a++) ref_state[a] = 1'b0;
    for (int s = 0; s < CH*FR; s++) ref_addr[s] = 0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_no_spurious_start();
    t_pattern_a();
    t_ignored_writes();
    t_pattern_b();
    t_fall_mid_set();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule